// File: doc/BRIEF.md
# Buffered SPI Controller with Cascaded Clock Prescaler

A serial peripheral interface controller for a 16-bit host register bus. It works either as the clock-driving end of the link (master) or as the clock-following end (slave). A single data register hides a transmit FIFO and a receive FIFO. In the default mode each FIFO holds one word. When the deep-buffer option is set, each holds eight words. A host write to the data register queues a word, and a host read takes the oldest received word.

In master mode, queued words are shifted out 16 bits at a time, MSB first, with no gap needed from software. Each word returns a received word at the same time. The serial clock comes from the system clock through two prescalers in series: a coarse one (1, 4, 16 or 64) and a fine one (1 to 8). In slave mode, the serial clock, the select line and the data input are synchronized to the system clock. A word is exchanged over every 16 rising edges. The select line is honoured when the select-enable bit or the clock-edge option bit is set.

The controller detects receive overflow and keeps a sticky flag. It can raise an interrupt pulse for every completed word.

Top module: `spi_bufctl`

## Requirements
- R1: After reset, STATUS (address 2) reads 0x0001, and `sck_o`, `sdo_o` and `irq_o` are low.
- R2: In master mode, `sck_o` idles low and has a period of 2·P·S system clocks. P is 1, 4, 16 or 64 for CTRL1[1:0] = 0, 1, 2 or 3. S is CTRL1[4:2] + 1.
- R3: The exchange starts when a word is written to DATA (address 3) while STATUS[15] (enable) and CTRL1[5] (master) are both 1. Master mode shifts 16 bits MSB first. `sdo_o` changes after a falling edge of `sck_o`, and `sdi_i` is sampled on the rising edge. The received word goes to the receive FIFO.
- R4: With CTRL2[0] = 1, each FIFO holds 8 words. Queued words are sent back to back, and the replies are read back in the order they were sent.
- R5: With CTRL2[0] = 0, each FIFO holds one word. A DATA write while the transmit FIFO is full is dropped and never sent.
- R6: STATUS[1] reads 1 when the transmit FIFO is full. STATUS[0] reads 1 when the receive FIFO is empty.
- R7: A word that completes while the receive FIFO is full is discarded and sets STATUS[6]. STATUS[6] stays set until a STATUS write with bit 6 = 0.
- R8: Reading DATA pops the oldest received word. Reading DATA while the receive FIFO is empty returns 0 and changes nothing.
- R9: When CTRL1[9] = 1, `irq_o` pulses for one cycle after each completed word. When CTRL1[9] = 0, it stays low.
- R10: In slave mode (CTRL1[5] = 0), the block samples `sdi_i` on rising `sck_i`. It presents the transmit FIFO head on `sdo_o`, MSB first, and completes a word every 16 rising edges. When the transmit FIFO is empty, it sends zeros.
- R11: In slave mode with CTRL1[8] (select enable) or CTRL1[6] (clock-edge option) set, edges of `sck_i` are ignored while `ss_n_i` is high. Receiving resumes once `ss_n_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 CTRL1, 1 CTRL2, 2 STATUS, 3 DATA |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears the next cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Word-complete interrupt pulse |

## Verification
On every cycle, the assertions check the following:
- the FIFOs never exceed the depth the mode allows;
- a push into a full FIFO leaves its count unchanged;
- the prescaler tick is spaced out whenever the ratio exceeds one;
- the master clock rests low when idle;
- every completed word arriving into a full receive FIFO sets the overflow flag;
- each interrupt pulse follows a completed word while the interrupt enable was set.

Only the bench scenarios can show the rest:
- the measured serial clock period for a given prescaler setting;
- MSB-first order and loopback content;
- eight-word ordering and the discarded ninth word;
- the slave exchange under an externally driven clock;
- the effect of the select line.

// File: rtl/spi_bufctl_pkg.sv
package spi_bufctl_pkg;
  localparam int WORD_W = 16;
  localparam int HP_W   = 10;

  // coarse ratio: code n gives 4**n
  function automatic logic [HP_W-1:0] pri_ratio(input logic [1:0] code);
    return HP_W'(1) << (2 * code);
  endfunction

  // system clocks per serial clock half period
  function automatic logic [HP_W-1:0] half_period(input logic [1:0] pcode,
                                                  input logic [2:0] scode);
    return pri_ratio(pcode) * (HP_W'(scode) + HP_W'(1));
  endfunction
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lim1,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, lim;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign lim     = lim1 ? CW'(1) : CW'(DEPTH);
  assign full    = (cnt >= lim);
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_bufctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] pri_code,
  input  logic [2:0] sec_code,
  output logic       tick
);
  logic [HP_W-1:0] hp, cnt;

  assign hp   = half_period(pri_code, sec_code);
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= hp - HP_W'(1);
    else if (cnt == '0)   cnt <= hp - HP_W'(1);
    else                  cnt <= cnt - HP_W'(1);
  end

  // R2
  tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && hp > HP_W'(1) && $stable(hp)) |=> !tick);
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mst,
  input  logic         tick,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_data,
  input  logic         sdi_raw,
  input  logic         sck_s,
  input  logic         ss_ok,
  input  logic         sdi_s,
  output logic         tx_pop,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         busy,
  output logic         sck_o,
  output logic         sdo_o
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  tx_sr, rx_sr;
  logic [BW-1:0] bitcnt;
  logic          sck_q, sck_d, need_load, done_q;
  logic          s_rise, s_fall, m_load, s_load;

  assign s_rise  = sck_s && !sck_d;
  assign s_fall  = !sck_s && sck_d;
  assign m_load  = en && mst && !busy && !tx_empty;
  assign s_load  = en && !mst && need_load && !sck_s;
  assign tx_pop  = m_load || (s_load && !tx_empty);
  assign done    = done_q;
  assign rx_word = rx_sr;
  assign sck_o   = sck_q;
  assign sdo_o   = mst ? (busy && tx_sr[W-1]) : (en && ss_ok && tx_sr[W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sck_q     <= 1'b0;
      sck_d     <= 1'b0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      bitcnt    <= '0;
      need_load <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      sck_d  <= sck_s;
      if (en && mst) begin
        need_load <= 1'b1;
        if (!busy) begin
          if (!tx_empty) begin
            busy   <= 1'b1;
            tx_sr  <= tx_data;
            bitcnt <= BW'(W - 1);
          end
        end else if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_sr <= {rx_sr[W-2:0], sdi_raw};
          end else begin
            sck_q <= 1'b0;
            tx_sr <= {tx_sr[W-2:0], 1'b0};
            if (bitcnt == '0) begin
              busy   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bitcnt <= bitcnt - BW'(1);
            end
          end
        end
      end else begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
        if (en) begin
          if (!ss_ok) begin
            bitcnt <= '0;
          end else if (s_rise) begin
            rx_sr <= {rx_sr[W-2:0], sdi_s};
            if (bitcnt == BW'(W - 1)) begin
              bitcnt    <= '0;
              done_q    <= 1'b1;
              need_load <= 1'b1;
            end else begin
              bitcnt <= bitcnt + BW'(1);
            end
          end
          if (s_load) begin
            need_load <= 1'b0;
            tx_sr     <= tx_empty ? '0 : tx_data;
          end else if (s_fall && ss_ok && !need_load) begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
          end
        end else begin
          need_load <= 1'b1;
          bitcnt    <= '0;
        end
      end
    end
  end

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mst && !busy) |-> !sck_q);
  // R3
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mst && $past(en && mst)) |-> !sck_q);
endmodule

// File: rtl/spi_bufctl.sv
module spi_bufctl
  import spi_bufctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sck_o,
  input  logic        sck_i,
  input  logic        ss_n_i,
  output logic        sdo_o,
  input  logic        sdi_i,
  output logic        irq_o
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b010;

  // control fields
  logic [1:0] pri_code;
  logic [2:0] sec_code;
  logic       mst, cke, ssen, ie, deep, en, ovf, irq_q;
  logic [15:0] rdata_q;

  // internal events
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tick, busy, ss_ok;
  logic [NSYNC-1:0]  raw_in, syn_in;

  assign raw_in = {sck_i, ss_n_i, sdi_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {2{SYNC_RST[g]}};
      else        ff <= {ff[0], raw_in[g]};
    end
    assign syn_in[g] = ff[1];
  end

  assign ss_ok   = (ssen || cke) ? !syn_in[1] : 1'b1;
  assign tx_push = bus_wr && (bus_addr == 2'd3);
  assign rx_pop  = bus_rd && (bus_addr == 2'd3) && !rx_empty;

  spi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .lim1(!deep), .push(tx_push), .pop(tx_pop),
    .din(bus_wdata), .dout(tx_head), .full(tx_full), .empty(tx_empty));

  spi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .lim1(!deep), .push(rx_push), .pop(rx_pop),
    .din(rx_word), .dout(rx_head), .full(rx_full), .empty(rx_empty));

  spi_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .pri_code(pri_code),
    .sec_code(sec_code), .tick(tick));

  spi_engine #(.W(WORD_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .tick(tick),
    .tx_empty(tx_empty), .tx_data(tx_head), .sdi_raw(sdi_i),
    .sck_s(syn_in[2]), .ss_ok(ss_ok), .sdi_s(syn_in[0]),
    .tx_pop(tx_pop), .done(rx_push), .rx_word(rx_word), .busy(busy),
    .sck_o(sck_o), .sdo_o(sdo_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_code <= '0;
      sec_code <= '0;
      mst      <= 1'b0;
      cke      <= 1'b0;
      ssen     <= 1'b0;
      ie       <= 1'b0;
      deep     <= 1'b0;
      en       <= 1'b0;
      ovf      <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= rx_push && ie;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin
            pri_code <= bus_wdata[1:0];
            sec_code <= bus_wdata[4:2];
            mst      <= bus_wdata[5];
            cke      <= bus_wdata[6];
            ssen     <= bus_wdata[8];
            ie       <= bus_wdata[9];
          end
          2'd1: deep <= bus_wdata[0];
          2'd2: begin
            en <= bus_wdata[15];
            if (!bus_wdata[6]) ovf <= 1'b0;
          end
          default: ;
        endcase
      end
      if (rx_push && rx_full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        2'd0:    rdata_q <= {6'b0, ie, ssen, 1'b0, cke, mst, sec_code, pri_code};
        2'd1:    rdata_q <= {15'b0, deep};
        2'd2:    rdata_q <= {en, 8'b0, ovf, 4'b0, tx_full, rx_empty};
        default: rdata_q <= rx_empty ? 16'h0000 : rx_head;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovf);
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(rx_push && ie));
endmodule

// File: tb/spi_bufctl_bench.sv
module spi_bufctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        sck_o, sdo_o, irq_o;
  logic        sck_i = 1'b0, ss_n_i = 1'b1, bsdi = 1'b0, lb = 1'b0;
  logic        sdi_i;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, cyc = 0;
  int last_rise = 0, prev_rise = 0;
  logic [15:0] mon = '0;
  logic        sck_d = 1'b0;

  always #4 clk = ~clk;
  assign sdi_i = lb ? sdo_o : bsdi;

  spi_bufctl u_spi_bufctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .sck_i(sck_i), .ss_n_i(ss_n_i), .sdo_o(sdo_o),
    .sdi_i(sdi_i), .irq_o(irq_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sck_d <= sck_o;
    if (irq_o) irq_cnt <= irq_cnt + 1;
    if (sck_o && !sck_d) begin
      prev_rise <= last_rise;
      last_rise <= cyc;
      mon <= {mon[14:0], sdo_o};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int target);
    for (int k = 0; k < 20000 && irq_cnt < target; k++) @(negedge clk);
  endtask

  // bench drives the serial clock as an external master
  task automatic ext_xfer(input logic [15:0] tx_in, output logic [15:0] rx_out);
    for (int i = 15; i >= 0; i--) begin
      bsdi = tx_in[i];
      repeat (8) @(negedge clk);
      rx_out[i] = sdo_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 sck_o", sck_o, 1'b0);
    chk("R1 sdo_o", sdo_o, 1'b0);
    chk("R1 irq_o", irq_o, 1'b0);
    rd(2'd2, d);
    chk("R1 status", d, 16'h0001);
  endtask

  task automatic t_master_single();
    logic [15:0] d;
    int base;
    lb = 1'b1;
    wr(2'd0, 16'h0220);          // master, irq enable, fastest clock
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h8000);
    base = irq_cnt;
    wr(2'd3, 16'hB38E);
    wait_irq(base + 1);
    chk("R3 msb-first on sdo", mon, 16'hB38E);
    chk("R9 one irq per word", irq_cnt - base, 1);
    rd(2'd3, d);
    chk("R3 loopback word", d, 16'hB38E);
    rd(2'd2, d);
    chk("R6 rx empty after read", d, 16'h8001);
  endtask

  task automatic t_prescaler(input int p, input int s);
    logic [15:0] d;
    int base, hp;
    hp = (4 ** p) * (s + 1);
    lb = 1'b1;
    base = irq_cnt;
    wr(2'd0, 16'h0020 | 16'(s << 2) | 16'(p));   // irq disabled
    wr(2'd3, 16'h5A3C);
    repeat (32 * hp + 40) @(negedge clk);
    chk("R2 sck period", last_rise - prev_rise, 2 * hp);
    chk("R2 sck idles low", sck_o, 1'b0);
    rd(2'd3, d);
    chk("R3 echo at divided clock", d, 16'h5A3C);
    chk("R9 no irq when disabled", irq_cnt - base, 0);
  endtask

  task automatic t_deep();
    logic [15:0] d;
    int base;
    lb = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0220);
    for (int i = 0; i < 9; i++) wr(2'd3, 16'h1100 + 16'(i * 17));
    rd(2'd2, d);
    chk("R6 tx full with 8 queued", d, 16'h0003);
    base = irq_cnt;
    wr(2'd2, 16'h8000);
    wait_irq(base + 8);
    repeat (60) @(negedge clk);
    chk("R4 eight words back to back", irq_cnt - base, 8);
    rd(2'd2, d);
    chk("R5 ninth word dropped, rx full", d, 16'h8000);
    wr(2'd3, 16'h7777);
    wait_irq(base + 9);
    rd(2'd2, d);
    chk("R7 overflow flag set", d, 16'h8040);
    for (int i = 0; i < 8; i++) begin
      rd(2'd3, d);
      chk("R4 fifo order", d, 16'h1100 + 16'(i * 17));
    end
    rd(2'd3, d);
    chk("R8 read of empty fifo", d, 16'h0000);
    rd(2'd2, d);
    chk("R7 flag sticky", d, 16'h8041);
    wr(2'd2, 16'h8040);
    rd(2'd2, d);
    chk("R7 write with bit6 set keeps flag", d, 16'h8041);
    wr(2'd2, 16'h8000);
    rd(2'd2, d);
    chk("R7 flag cleared", d, 16'h8001);
  endtask

  task automatic t_single_depth();
    logic [15:0] d;
    int base;
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0220);
    wr(2'd3, 16'h2468);
    rd(2'd2, d);
    chk("R5 tx full after one word", d, 16'h0003);
    wr(2'd3, 16'h1357);
    lb = 1'b0; bsdi = 1'b1;
    base = irq_cnt;
    wr(2'd2, 16'h8000);
    wait_irq(base + 1);
    repeat (200) @(negedge clk);
    chk("R5 second word never sent", irq_cnt - base, 1);
    chk("R3 last word on sdo", mon, 16'h2468);
    rd(2'd3, d);
    chk("R3 sdi sampled", d, 16'hFFFF);
    bsdi = 1'b0;
  endtask

  task automatic t_slave();
    logic [15:0] d, got;
    lb = 1'b0;
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0000);          // slave, no select gating
    wr(2'd3, 16'hA5C3);
    wr(2'd3, 16'h0F0F);
    wr(2'd2, 16'h8000);
    repeat (10) @(negedge clk);
    ext_xfer(16'h3C96, got);
    chk("R10 slave sends head word", got, 16'hA5C3);
    ext_xfer(16'hC001, got);
    chk("R10 slave sends second word", got, 16'h0F0F);
    ext_xfer(16'h0000, got);
    chk("R10 slave sends zeros when empty", got, 16'h0000);
    rd(2'd3, d);
    chk("R10 slave received word", d, 16'h3C96);
    rd(2'd3, d);
    chk("R10 slave second received", d, 16'hC001);
    rd(2'd3, d);
  endtask

  task automatic t_select();
    logic [15:0] d, got;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0040);          // slave with clock-edge option
    wr(2'd2, 16'h8000);
    ss_n_i = 1'b1;
    repeat (10) @(negedge clk);
    ext_xfer(16'hFFFF, got);
    rd(2'd2, d);
    chk("R11 clock ignored while deselected", d, 16'h8001);
    ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    ext_xfer(16'h1234, got);
    rd(2'd3, d);
    chk("R11 received once selected", d, 16'h1234);
    ss_n_i = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_master_single();
    t_prescaler(0, 2);
    t_prescaler(1, 0);
    t_prescaler(1, 1);
    t_deep();
    t_single_depth();
    t_slave();
    t_select();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule